// File: doc/BRIEF.md
# Data Memory Decoder with Wait States

This block steers each data-memory access made through a 24-bit data pointer. An access goes either to a 2 KB on-chip extended RAM or to an external bus. When the overlay enable is set, the lowest 2 KB of the 16 MB data space map to the on-chip RAM and every higher address goes off chip. When the enable is clear, every access goes off chip. External accesses are stretched by a programmable count of 0 to 7 machine cycles. Internal accesses always take one machine cycle.

Requests arrive on a valid/ready handshake. An access is accepted on a rising edge where `req_valid` and `req_ready` are both high. Address, direction, write data, overlay enable and wait count are captured at that edge. `req_ready` is low while an access is in flight, except in its final cycle, so a requester that holds `req_valid` high is stalled until then. In that final cycle `done` pulses and a new access can be accepted back to back. The requester must hold its request fields stable while `req_valid` is high and `req_ready` is low. A machine cycle is `MC_CLKS` clocks.

While no external access is running, `pins_free` is high. The shared bus pins can then serve as general I/O.

Top module: `dmem_wait_decoder`

## Requirements
- R1: With `cfg_en`=1, an address in 000000h..0007FFh goes to the on-chip RAM. `int_cs` is high for the whole access, `int_addr` carries the low 11 address bits, and `ext_rd`/`ext_wr` stay low.
- R2: With `cfg_en`=1, any address of 000800h or above goes to the external bus, and `int_cs` stays low.
- R3: With `cfg_en`=0, every address goes to the external bus, including 000000h..0007FFh.
- R4: An internal access ends with `done` high in the `MC_CLKS`-th clock after the accepting edge.
- R5: An external access ends with `done` high in the (4+n)*`MC_CLKS`-th clock after the accepting edge, where n is the 3-bit `wait_cnt` (0..7).
- R6: `pins_free` is high when idle and during internal accesses, and low during external accesses.
- R7: `done` is high for exactly one clock per access. During that clock, `rd_data` equals the read data of the selected target.
- R8: `req_ready` is low during an access except in its `done` cycle. A request held valid is accepted only at that point.
- R9: For an external read, `ext_rd` is high and `ext_wr` is low. For a write, `ext_wr` (external) or `int_we` (internal) is high for the whole access, and `ext_wdata`/`int_wdata` carry the write data. `ext_addr` is stable during the access.
- R10: After reset, the block is idle: `req_ready`=1, `done`=0, all strobes low and `pins_free`=1.
- R11: `cfg_en` and `wait_cnt` are sampled only at acceptance. Changing them during an access changes neither its target nor its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Data pointer address |
| req_wdata | input | 8 | Write data |
| cfg_en | input | 1 | On-chip RAM overlay enable |
| wait_cnt | input | 3 | Extra machine cycles for external accesses |
| int_cs | output | 1 | On-chip RAM select |
| int_we | output | 1 | On-chip RAM write enable |
| int_addr | output | 11 | On-chip RAM address |
| int_wdata | output | 8 | On-chip RAM write data |
| int_rdata | input | 8 | On-chip RAM read data |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_addr | output | 24 | External address |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data |
| done | output | 1 | One-clock end-of-access pulse |
| rd_data | output | 8 | Read data, valid while done is high |
| pins_free | output | 1 | Bus pins free for general I/O |

## Verification
The bench probes the decode boundary from both sides: 0007FFh against 000800h, plus 000000h and FFFFFFh. A comparator off by one would route one of these to the wrong side. Low addresses with the overlay disabled catch a decoder that ignores the enable. Access lengths are timed for wait counts 0 and 7 and for values in between, which exposes a missing base cycles term or a wait value that is not scaled by the machine cycle. Holding `req_valid` high across two accesses, and changing `cfg_en` and `wait_cnt` mid-access, catch a design that restarts early or re-reads its configuration after acceptance.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  typedef enum logic {
    ROUTE_EXT = 1'b0,
    ROUTE_INT = 1'b1
  } route_t;
endpackage

// File: rtl/dmd_addr_decode.sv
module dmd_addr_decode
  import dmd_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int IRAM_AW = 11
) (
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] addr,
  output route_t            route
);
  localparam int HI_W = ADDR_W - IRAM_AW;

  logic in_window;
  assign in_window = (addr[ADDR_W-1:IRAM_AW] == {HI_W{1'b0}});
  assign route     = (cfg_en && in_window) ? ROUTE_INT : ROUTE_EXT;

  // R3: with the overlay disabled nothing is decoded as internal
  always_comb begin
    a_r3_no_int_when_off : assert (cfg_en || route == ROUTE_EXT);
  end
endmodule

// File: rtl/dmd_wait_timer.sv
module dmd_wait_timer
  import dmd_pkg::*;
#(
  parameter int WAIT_W      = 3,
  parameter int MC_CLKS     = 2,
  parameter int EXT_BASE_MC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  route_t            route,
  input  logic [WAIT_W-1:0] wait_n,
  output logic              busy,
  output logic              last
);
  localparam int MAX_LEN = (EXT_BASE_MC + (1 << WAIT_W) - 1) * MC_CLKS;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len;

  always_comb begin
    if (route == ROUTE_INT) len = CNT_W'(MC_CLKS);
    else                    len = CNT_W'((EXT_BASE_MC + int'(wait_n)) * MC_CLKS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= len - CNT_W'(1);
    end else if (busy && cnt == '0) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign last = busy && (cnt == '0);

  // R5: the down-counter never exceeds the longest external access
  a_r5_cnt_in_range : assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(cnt) < MAX_LEN));
  // R4: a running count that is not at zero keeps the access alive next clock
  a_r4_keeps_busy : assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
endmodule

// File: rtl/dmem_wait_decoder.sv
module dmem_wait_decoder
  import dmd_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 8,
  parameter int IRAM_AW     = 11,
  parameter int WAIT_W      = 3,
  parameter int MC_CLKS     = 2,
  parameter int EXT_BASE_MC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_wr,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               cfg_en,
  input  logic [WAIT_W-1:0]  wait_cnt,
  output logic               int_cs,
  output logic               int_we,
  output logic [IRAM_AW-1:0] int_addr,
  output logic [DATA_W-1:0]  int_wdata,
  input  logic [DATA_W-1:0]  int_rdata,
  output logic               ext_rd,
  output logic               ext_wr,
  output logic [ADDR_W-1:0]  ext_addr,
  output logic [DATA_W-1:0]  ext_wdata,
  input  logic [DATA_W-1:0]  ext_rdata,
  output logic               done,
  output logic [DATA_W-1:0]  rd_data,
  output logic               pins_free
);
  route_t             dec_route;
  route_t             cur_route;
  logic               busy;
  logic               last;
  logic               accept;
  logic [ADDR_W-1:0]  cur_addr;
  logic [DATA_W-1:0]  cur_wdata;
  logic               cur_wr;
  logic               on_chip;
  logic               off_chip;

  dmd_addr_decode #(
    .ADDR_W (ADDR_W),
    .IRAM_AW(IRAM_AW)
  ) u_decode (
    .cfg_en(cfg_en),
    .addr  (req_addr),
    .route (dec_route)
  );

  assign req_ready = !busy || last;
  assign accept    = req_valid && req_ready;

  dmd_wait_timer #(
    .WAIT_W     (WAIT_W),
    .MC_CLKS    (MC_CLKS),
    .EXT_BASE_MC(EXT_BASE_MC)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .route (dec_route),
    .wait_n(wait_cnt),
    .busy  (busy),
    .last  (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_route <= ROUTE_EXT;
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_wr    <= 1'b0;
    end else if (accept) begin
      cur_route <= dec_route;
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
      cur_wr    <= req_wr;
    end
  end

  assign on_chip  = busy && (cur_route == ROUTE_INT);
  assign off_chip = busy && (cur_route == ROUTE_EXT);

  assign int_cs    = on_chip;
  assign int_we    = on_chip && cur_wr;
  assign int_addr  = cur_addr[IRAM_AW-1:0];
  assign int_wdata = cur_wdata;

  assign ext_rd    = off_chip && !cur_wr;
  assign ext_wr    = off_chip && cur_wr;
  assign ext_addr  = cur_addr;
  assign ext_wdata = cur_wdata;

  assign pins_free = !off_chip;
  assign done      = last;
  assign rd_data   = (cur_route == ROUTE_INT) ? int_rdata : ext_rdata;

  // R1/R6: the on-chip select and the external strobes never overlap
  a_r1_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
    int_cs |-> !(ext_rd || ext_wr));
  // R6: any external strobe implies the pins are claimed
  a_r6_pins_claimed : assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd || ext_wr) |-> !pins_free);
  // R1: an on-chip access always lies inside the low window
  a_r1_window : assert property (@(posedge clk) disable iff (!rst_n)
    int_cs |-> (cur_addr < ADDR_W'(1 << IRAM_AW)));
  // R8: no acceptance while an access is in flight and not finishing
  a_r8_hold_off : assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |-> !req_ready);
  // R9: address stays put within an access
  a_r9_addr_stable : assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(ext_addr));
  // R7: done only ever marks an access in flight
  a_r7_done_in_access : assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int_cs || ext_rd || ext_wr));
endmodule

// File: tb/dmem_wait_decoder_tb_top.sv
module dmem_wait_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MC         = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_wr = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        cfg_en = 1'b0;
  logic [2:0]  wait_cnt = '0;
  logic        int_cs, int_we, ext_rd, ext_wr, done, pins_free;
  logic [10:0] int_addr;
  logic [7:0]  int_wdata, int_rdata, ext_wdata, ext_rdata, rd_data;
  logic [23:0] ext_addr;

  int checks = 0;
  int errors = 0;

  // Simple read-data models driven from the block's own address outputs
  assign int_rdata = int_addr[7:0] ^ 8'h3C;
  assign ext_rdata = ext_addr[7:0] ^ ext_addr[23:16];

  always #(CLK_PERIOD/2) clk = ~clk;

  dmem_wait_decoder #(.MC_CLKS(MC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_en(cfg_en), .wait_cnt(wait_cnt), .int_cs(int_cs), .int_we(int_we),
    .int_addr(int_addr), .int_wdata(int_wdata), .int_rdata(int_rdata),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .done(done),
    .rd_data(rd_data), .pins_free(pins_free)
  );

  // {exp_int, cfg, wr, wait[2:0], addr[23:0]}
  localparam logic [29:0] VEC [8] = '{
    {1'b1, 1'b1, 1'b0, 3'd3, 24'h000000},
    {1'b1, 1'b1, 1'b1, 3'd0, 24'h0007FF},
    {1'b0, 1'b1, 1'b0, 3'd0, 24'h000800},
    {1'b0, 1'b1, 1'b1, 3'd7, 24'hFFFFFF},
    {1'b0, 1'b0, 1'b0, 3'd2, 24'h000000},
    {1'b0, 1'b0, 1'b1, 3'd5, 24'h0007FF},
    {1'b0, 1'b1, 1'b0, 3'd1, 24'h123456},
    {1'b1, 1'b1, 1'b0, 3'd7, 24'h000400}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_access(input bit cfg, input bit wr, input logic [2:0] wt,
                            input logic [23:0] addr, input bit exp_int,
                            input string rtag, input bit disturb);
    int cyc;
    int exp_len;
    bit ready_bad;
    logic [7:0] exp_rd;
    exp_len = exp_int ? MC : (4 + int'(wt)) * MC;
    exp_rd  = exp_int ? (addr[7:0] ^ 8'h3C) : (addr[7:0] ^ addr[23:16]);
    @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_addr = addr;
    req_wdata = addr[7:0] ^ 8'h5A; cfg_en = cfg; wait_cnt = wt;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (disturb) begin
      cfg_en = ~cfg; wait_cnt = 3'd7;   // R11: must not matter now
    end
    cyc = 1;
    if (exp_int) begin
      check(int_cs && !ext_rd && !ext_wr, rtag, "internal route", {int_cs, ext_rd, ext_wr}, 3'b100);
      check(int_addr == addr[10:0], "R1", "int_addr", int_addr, addr[10:0]);
      check(pins_free == 1'b1, "R6", "pins_free internal", pins_free, 1);
      if (wr) check(int_we && int_wdata == (addr[7:0] ^ 8'h5A), "R9", "int write", int_wdata, addr[7:0] ^ 8'h5A);
    end else begin
      check(!int_cs && ext_rd == !wr && ext_wr == wr, rtag, "external route",
            {int_cs, ext_rd, ext_wr}, {1'b0, !wr, wr});
      check(ext_addr == addr, "R9", "ext_addr", ext_addr, addr);
      check(pins_free == 1'b0, "R6", "pins_free external", pins_free, 0);
      if (wr) check(ext_wdata == (addr[7:0] ^ 8'h5A), "R9", "ext write data", ext_wdata, addr[7:0] ^ 8'h5A);
    end
    ready_bad = 1'b0;
    while (!done && cyc < 40) begin
      if (req_ready) ready_bad = 1'b1;
      @(negedge clk);
      cyc++;
    end
    check(cyc == exp_len, exp_int ? "R4" : "R5", "access length", cyc, exp_len);
    check(!ready_bad && req_ready, "R8", "ready during access", ready_bad, 0);
    if (!wr) check(rd_data == exp_rd, "R7", "rd_data at done", rd_data, exp_rd);
    @(negedge clk);
    check(!done && req_ready && pins_free, "R7", "done single pulse", done, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int dones;
    bit pulse_ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(req_ready && !done && !int_cs && !ext_rd && !ext_wr && pins_free,
          "R10", "idle after reset",
          {req_ready, done, int_cs, ext_rd, ext_wr, pins_free}, 6'b100001);

    for (int i = 0; i < 8; i++) begin
      logic [29:0] v;
      string tg;
      v = VEC[i];
      tg = v[29] ? "R1" : (v[28] ? "R2" : "R3");
      run_access(v[28], v[27], v[26:24], v[23:0], v[29], tg, 1'b0);
    end

    // R11: change cfg_en and wait_cnt during an access
    run_access(1'b1, 1'b0, 3'd1, 24'h000900, 1'b0, "R11", 1'b1);
    run_access(1'b1, 1'b0, 3'd0, 24'h000010, 1'b1, "R11", 1'b1);

    // R8: request held valid across two back-to-back external accesses (8 clocks each)
    @(negedge clk);
    req_valid = 1'b1; req_wr = 1'b0; req_addr = 24'h000800; cfg_en = 1'b1; wait_cnt = 3'd0;
    @(posedge clk);
    dones = 0;
    pulse_ok = 1'b1;
    for (int c = 1; c <= 16; c++) begin
      @(negedge clk);
      if (done) dones++;
      if (done != (c == 8 || c == 16)) pulse_ok = 1'b0;
      if (req_ready != (c == 8 || c == 16)) pulse_ok = 1'b0;
      if (c == 16) req_valid = 1'b0;
    end
    check(dones == 2, "R8", "back-to-back done count", dones, 2);
    check(pulse_ok, "R8", "back-to-back done/ready timing", pulse_ok, 1);
    @(negedge clk);
    check(!done && req_ready && pins_free, "R10", "idle after back-to-back", done, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule